// File: doc/BRIEF.md
# Radio Serial Register Programmer

This block writes one register word at a time into an external RF synthesizer or IF chip over a three-wire serial link. The link has a shared serial clock, shared serial data, and one latch-enable line for each of the two chips. The host starts a transfer with a single-cycle write strobe. The strobe carries a 24-bit payload, which holds both the target register id and the data, a 5-bit length and a chip select. The block then shifts out the requested number of low-order payload bits, most significant first. After the last bit it raises the latch-enable of the chosen chip for one serial period. A busy output stays high from acceptance until the transfer is complete.

Lengths of 20 and 22 bits cover the two usual chip families. Any length from 1 to 24 is accepted. A length of 0, or a length above 24, is dropped at once and the interface does not move. The serial clock is the system clock divided by the parameter `CLK_DIV`. The block also carries the RF PLL lock-detect pin through a two-flop synchronizer onto a status output.

Top module: `radio_ser_prog`

## Requirements
- R1: After reset, `busy`, `ser_clk`, `ser_data`, `le_rf` and `le_if` are all 0.
- R2: A write with a length N of 1 to 24 that arrives while idle raises `busy` at the next clock edge. `busy` then stays high for exactly (N+1)*CLK_DIV+1 system cycles.
- R3: Exactly N rising edges of `ser_clk` occur. On those edges `ser_data` carries payload bit N-1 first and bit 0 last. Payload bits N and above are never sent.
- R4: Each bit occupies one serial period of CLK_DIV system cycles. `ser_clk` is low for the first CLK_DIV/2 cycles and high for the rest. `ser_data` changes only while `ser_clk` is low.
- R5: Select value 0 targets `le_rf` and value 1 targets `le_if`. After the last bit, the targeted latch-enable is high for exactly CLK_DIV cycles while `ser_clk` is low. The other latch-enable stays low, and the two are never high together.
- R6: A write that arrives while `busy` is high is ignored. It changes neither the bits sent nor the latch line used, and it does not start a second transfer afterwards.
- R7: A write with a length of 0 or above 24 leaves `busy` low and produces no activity on `ser_clk`, `ser_data`, `le_rf` or `le_if`.
- R8: `pll_locked` equals the value `pll_lock_in` had two clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Single-cycle write strobe for a new transfer |
| cfg_payload | input | 24 | Register id and data to send |
| cfg_nbits | input | 5 | Number of low-order payload bits to send |
| cfg_sel_if | input | 1 | 1 selects the IF chip, 0 selects the RF chip |
| pll_lock_in | input | 1 | Asynchronous RF PLL lock-detect pin |
| busy | output | 1 | High while a transfer is in progress |
| pll_locked | output | 1 | Synchronized lock-detect status |
| ser_clk | output | 1 | Serial clock to both chips |
| ser_data | output | 1 | Serial data to both chips |
| le_rf | output | 1 | Latch-enable of the RF chip |
| le_if | output | 1 | Latch-enable of the IF chip |

## Verification
The properties assume that `cfg_wr` is a clean synchronous pulse. They also assume the payload, length and select are valid in the same cycle as the strobe, and they take no account of these fields at any other time. `pll_lock_in` may change at any cycle; its property is checked only once the synchronizer has been refilled after reset. The stimulus changes every input half a clock period away from the sampling edge. It holds each strobe for exactly one cycle, and it places the write that collides with a busy transfer well inside the shift phase, so that R6 is exercised while bits are actually moving.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    localparam int PAYLOAD_W = 24;
    localparam int NBITS_W   = 5;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_SHIFT = 2'd1,
        RSP_LATCH = 2'd2,
        RSP_TAIL  = 2'd3
    } rsp_state_e;

    typedef struct packed {
        logic [PAYLOAD_W-1:0] payload;
        logic [NBITS_W-1:0]   nbits;
        logic                 sel_if;
    } rsp_req_t;

    // Length is usable when it lies in 1..PAYLOAD_W.
    function automatic logic nbits_ok(input logic [NBITS_W-1:0] n);
        return (n != '0) && (int'(n) <= PAYLOAD_W);
    endfunction

    // Move bit n-1 of the payload up to the top of the shift register.
    function automatic logic [PAYLOAD_W-1:0] align_msb(
        input logic [PAYLOAD_W-1:0] p,
        input logic [NBITS_W-1:0]   n
    );
        logic [NBITS_W-1:0] gap;
        gap = NBITS_W'(PAYLOAD_W) - n;
        return p << gap;
    endfunction

endpackage

// File: rtl/rsp_phase.sv
module rsp_phase #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic ph_last,
    output logic clk_hi
);
    localparam int PH_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int HALF = CLK_DIV / 2;

    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ph_q <= '0;
        end else if (ph_last) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    assign ph_last = (ph_q == PH_W'(CLK_DIV - 1));
    assign clk_hi  = (ph_q >= PH_W'(HALF));
endmodule

// File: rtl/rsp_shifter.sv
module rsp_shifter
    import rsp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 shift,
    input  logic [PAYLOAD_W-1:0] payload,
    input  logic [NBITS_W-1:0]   nbits,
    output logic                 sdo,
    output logic                 last_bit
);
    logic [PAYLOAD_W-1:0] sr_q;
    logic [NBITS_W-1:0]   left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            left_q <= '0;
        end else if (load) begin
            sr_q   <= align_msb(payload, nbits);
            left_q <= nbits;
        end else if (shift) begin
            sr_q   <= {sr_q[PAYLOAD_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end
    end

    assign sdo      = sr_q[PAYLOAD_W-1];
    assign last_bit = (left_q == NBITS_W'(1));
endmodule

// File: rtl/rsp_fsm.sv
module rsp_fsm
    import rsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  rsp_req_t   req,
    input  logic       ph_last,
    input  logic       last_bit,
    output rsp_state_e state,
    output logic       load,
    output logic       shift,
    output logic       run,
    output logic       sel_if_q
);
    rsp_state_e st_q, st_d;
    logic       sel_q;

    always_comb begin
        st_d  = st_q;
        load  = 1'b0;
        shift = 1'b0;
        unique case (st_q)
            RSP_IDLE: begin
                if (wr && nbits_ok(req.nbits)) begin
                    load = 1'b1;
                    st_d = RSP_SHIFT;
                end
            end
            RSP_SHIFT: begin
                if (ph_last) begin
                    shift = 1'b1;
                    if (last_bit) st_d = RSP_LATCH;
                end
            end
            RSP_LATCH: begin
                if (ph_last) st_d = RSP_TAIL;
            end
            RSP_TAIL: st_d = RSP_IDLE;
            default:  st_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= RSP_IDLE;
            sel_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (load) sel_q <= req.sel_if;
        end
    end

    assign state    = st_q;
    assign run      = (st_q == RSP_SHIFT) || (st_q == RSP_LATCH);
    assign sel_if_q = sel_q;
endmodule

// File: rtl/radio_ser_prog.sv
module radio_ser_prog
    import rsp_pkg::*;
#(
    parameter int CLK_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic [PAYLOAD_W-1:0] cfg_payload,
    input  logic [NBITS_W-1:0]   cfg_nbits,
    input  logic                 cfg_sel_if,
    input  logic                 pll_lock_in,
    output logic                 busy,
    output logic                 pll_locked,
    output logic                 ser_clk,
    output logic                 ser_data,
    output logic                 le_rf,
    output logic                 le_if
);
    rsp_req_t   req;
    rsp_state_e state;
    logic       load, shift, run, sel_q;
    logic       ph_last, clk_hi, sdo, last_bit;

    assign req = '{payload: cfg_payload, nbits: cfg_nbits, sel_if: cfg_sel_if};

    rsp_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .wr       (cfg_wr),
        .req      (req),
        .ph_last  (ph_last),
        .last_bit (last_bit),
        .state    (state),
        .load     (load),
        .shift    (shift),
        .run      (run),
        .sel_if_q (sel_q)
    );

    rsp_phase #(.CLK_DIV(CLK_DIV)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .ph_last (ph_last),
        .clk_hi  (clk_hi)
    );

    rsp_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .shift    (shift),
        .payload  (cfg_payload),
        .nbits    (cfg_nbits),
        .sdo      (sdo),
        .last_bit (last_bit)
    );

    // Lock-detect synchronizer
    logic [SYNC_STAGES-1:0] sync_q;
    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) sync_q[i] <= 1'b0;
                else     sync_q[i] <= (i == 0) ? pll_lock_in : sync_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign pll_locked = sync_q[SYNC_STAGES-1];
    assign busy       = (state != RSP_IDLE);
    assign ser_clk    = (state == RSP_SHIFT) && clk_hi;
    assign ser_data   = (state == RSP_SHIFT) && sdo;
    assign le_rf      = (state == RSP_LATCH) && !sel_q;
    assign le_if      = (state == RSP_LATCH) &&  sel_q;
endmodule

// File: rtl/radio_ser_prog_chk.sv
module radio_ser_prog_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_wr,
    input logic [4:0] cfg_nbits,
    input logic       pll_lock_in,
    input logic       busy,
    input logic       pll_locked,
    input logic       ser_clk,
    input logic       ser_data,
    input logic       le_rf,
    input logic       le_if
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ser_clk && !ser_data && !le_rf && !le_if));

    // R2
    start_by_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cfg_wr));

    // R4
    data_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    // R5
    one_latch_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({le_rf, le_if}));

    // R5
    latch_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
        (le_rf || le_if) |-> !ser_clk);

    // R7
    bad_len_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && cfg_wr && (cfg_nbits == 5'd0 || cfg_nbits > 5'd24)) |=> !busy);

    // R8
    lock_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (pll_locked == $past(pll_lock_in, 2)));
endmodule

bind radio_ser_prog radio_ser_prog_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr      (cfg_wr),
    .cfg_nbits   (cfg_nbits),
    .pll_lock_in (pll_lock_in),
    .busy        (busy),
    .pll_locked  (pll_locked),
    .ser_clk     (ser_clk),
    .ser_data    (ser_data),
    .le_rf       (le_rf),
    .le_if       (le_if)
);

// File: tb/radio_ser_prog_bench.sv
module radio_ser_prog_bench;
    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [23:0] cfg_payload;
    logic [4:0]  cfg_nbits;
    logic        cfg_sel_if;
    logic        pll_lock_in;
    logic        busy, pll_locked, ser_clk, ser_data, le_rf, le_if;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    radio_ser_prog #(.CLK_DIV(D)) u_radio_ser_prog (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_payload(cfg_payload),
        .cfg_nbits(cfg_nbits), .cfg_sel_if(cfg_sel_if), .pll_lock_in(pll_lock_in),
        .busy(busy), .pll_locked(pll_locked), .ser_clk(ser_clk), .ser_data(ser_data),
        .le_rf(le_rf), .le_if(le_if)
    );

    // Observation counters
    logic [23:0] cap;
    int edges, busy_n, rf_n, if_n, data_hi_n;
    int rise_gap, last_rise, rise_bad;

    always @(posedge ser_clk) begin
        cap   = {cap[22:0], ser_data};
        edges = edges + 1;
    end

    always @(negedge clk) begin
        cycles = cycles + 1;
        if (busy)     busy_n    = busy_n + 1;
        if (le_rf)    rf_n      = rf_n + 1;
        if (le_if)    if_n      = if_n + 1;
        if (ser_data) data_hi_n = data_hi_n + 1;
    end

    task automatic clear_obs();
        cap = '0; edges = 0; busy_n = 0; rf_n = 0; if_n = 0; data_hi_n = 0;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic pulse_wr(input logic [23:0] p, input logic [4:0] n, input logic s);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_payload = p; cfg_nbits = n; cfg_sel_if = s;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_payload = '0; cfg_nbits = '0; cfg_sel_if = 1'b0;
    endtask

    task automatic xfer(input logic [23:0] p, input int n, input logic s, input bit inject);
        logic [24:0] mask;
        clear_obs();
        mask = (25'd1 << n) - 25'd1;
        pulse_wr(p, 5'(n), s);
        // R2: busy visible right after the accepting edge
        check("R2 busy raised", int'(busy), 1);
        if (inject) begin
            repeat (5) @(negedge clk);
            cfg_wr = 1'b1; cfg_payload = ~p; cfg_nbits = 5'd24; cfg_sel_if = ~s;
            @(negedge clk);
            cfg_wr = 1'b0;
        end
        for (int k = 0; k < 200 && busy; k++) @(negedge clk);
        check("R2 busy length", busy_n, (n + 1) * D + 1);
        check("R3 edge count", edges, n);
        check("R3 bits", int'(cap & mask[23:0]), int'(p & mask[23:0]));
        check("R5 selected latch", s ? if_n : rf_n, D);
        check("R5 other latch", s ? rf_n : if_n, 0);
        repeat (4) @(negedge clk);
        // R6: no queued restart after an ignored write
        if (inject) check("R6 no restart", int'(busy), 0);
    endtask

    task automatic bad_len(input logic [4:0] n);
        clear_obs();
        pulse_wr(24'hFFFFFF, n, 1'b1);
        repeat (3 * D) @(negedge clk);
        check("R7 busy", busy_n, 0);
        check("R7 clk edges", edges, 0);
        check("R7 latches", rf_n + if_n, 0);
        check("R7 data", data_hi_n, 0);
    endtask

    // {sel, nbits, payload}
    localparam logic [29:0] VEC [6] = '{
        {1'b0, 5'd20, 24'hA5C33C},
        {1'b1, 5'd22, 24'h3FFFFF},
        {1'b0, 5'd24, 24'h800001},
        {1'b1, 5'd1,  24'h000001},
        {1'b0, 5'd1,  24'hFFFFFE},
        {1'b0, 5'd22, 24'h123456}
    };

    initial begin
        rst = 1'b1; cfg_wr = 0; cfg_payload = '0; cfg_nbits = '0; cfg_sel_if = 0;
        pll_lock_in = 0;
        clear_obs();
        repeat (3) @(negedge clk);
        // R1
        check("R1 busy", int'(busy), 0);
        check("R1 outputs", int'({ser_clk, ser_data, le_rf, le_if}), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", int'({busy, ser_clk, ser_data, le_rf, le_if}), 0);

        for (int i = 0; i < 6; i++)
            xfer(VEC[i][23:0], int'(VEC[i][28:24]), VEC[i][29], 1'b0);

        // R4: serial period and low/high split, 3-bit word 101
        clear_obs();
        pulse_wr(24'h000005, 5'd3, 1'b0);
        for (int k = 0; k < 3 * D; k++) begin
            check("R4 clk phase", int'(ser_clk), ((k % D) >= D / 2) ? 1 : 0);
            check("R4 data", int'(ser_data), (k / D == 1) ? 0 : 1);
            @(negedge clk);
        end
        check("R5 latch after last bit", int'(le_rf), 1);
        for (int k = 0; k < 20 && busy; k++) @(negedge clk);

        // R6
        xfer(24'h5A5A5A, 20, 1'b0, 1'b1);
        xfer(24'h0F0F0F, 22, 1'b1, 1'b1);

        // R7
        bad_len(5'd0);
        bad_len(5'd25);
        bad_len(5'd31);

        // R8
        pll_lock_in = 1'b1;
        @(negedge clk);
        check("R8 one cycle", int'(pll_locked), 0);
        @(negedge clk);
        check("R8 two cycles", int'(pll_locked), 1);
        pll_lock_in = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 fall", int'(pll_locked), 0);

        summary();
    end

    initial begin
        while (cycles < 150000) @(negedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        summary();
    end
endmodule